// File: doc/BRIEF.md
# Modulo-M Direct Digital Synthesiser

This block turns a fixed system clock into a stream of sampled sine values whose frequency is set at run time. A phase accumulator advances by a programmable step on every clock. It wraps at a programmable modulus, so that modulus can be any value and need not be a power of two. The output frequency is therefore Fclk * step / modulus. For example, a modulus of 256 with a step of one gives Fclk/256, which needs a clock of about 35 MHz for a 137 kHz tone.

A phase offset is added to the accumulator value on its way to the waveform stage and is never fed back into the accumulator. This lets phase keying (for example a 180-degree flip with offset = modulus/2) happen without disturbing the running phase. The offset sum is reduced by the modulus and scaled to an 8-bit table address. A piecewise-parabolic shaper turns that address into an 8-bit offset-binary sample. The sample is registered, so it can drive a resistor ladder or a parallel DAC directly.

The sample stream is free-running: one new sample every clock with no handshake, since the converter it feeds cannot apply back-pressure. All configuration inputs are plain levels, sampled every clock.

Top module: `dds_modm_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the captured step, modulus and offset, and the address register. While reset is held, and on the first edge after it is released with all configuration inputs at zero, sample_o reads 128.
- R2: On each clock the accumulator becomes acc + N when that is below M, and acc + N - M otherwise. With N < M it stays in 0..M-1, and the waveform repeats at Fclk * N / M.
- R3: If the value after one subtraction of M is still at least M (N >= M, or M lowered below the running value), the accumulator loads 0. The phase sum of R6 follows the same rule.
- R4: While the captured modulus is zero, the accumulator is held at 0 and the table address is 0.
- R5: step_i, modulus_i and offset_i are captured on every clock edge. A value present at edge k is first used by the accumulator and the phase adder at edge k+1.
- R6: The lookup phase is acc + offset, reduced once by M under the R3 rule. The offset never changes the accumulator sequence.
- R7: The table address is floor(phase * 256 / M).
- R8: For address a, let x = a mod 128 and g = min((x * (128 - x)) >> 5, 127). The sample is 128 + g when a < 128 and 127 - g when a >= 128. For example, address 0 gives 128, 64 gives 255, 128 gives 127 and 192 gives 0.
- R9: sample_o is registered. A new offset applied before edge k appears on sample_o after edge k+2.
- R10: With M = 256, N = 1 and offset 0, the address equals the accumulator and the sample sequence repeats every 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | ACC_W | Phase step N added each clock |
| modulus_i | input | ACC_W | Accumulator modulus M |
| offset_i | input | ACC_W | Phase offset added after the accumulator |
| sample_o | output | 8 | Registered offset-binary sine sample |

## Verification
The bench targets the wrap boundaries. These are a step of M-1, a step larger than M, a modulus lowered below the running value, and a modulus of 65535 where the raw sum overflows the accumulator width. A missing carry bit or a missing second range check would let the accumulator escape 0..M-1 and produce a corrupted, non-periodic waveform. An offset that pushes the phase past M, and past 2M, catches an offset adder that is not reduced. A zero modulus catches a divider or wrap path that runs away. Directed steps of the offset count the exact two-edge latency and probe the shaper at its peak, trough and zero crossings, so an extra or missing pipeline stage or a swapped half-wave polarity shows up as a miscompare.

// File: rtl/dds_pkg.sv
package dds_pkg;
  // Width of the parallel sample bus
  localparam int unsigned SAMP_W = 8;
  // Mid-scale code of an offset-binary sample
  localparam logic [SAMP_W-1:0] SAMP_MID = SAMP_W'(1) << (SAMP_W - 1);
endpackage

// File: rtl/dds_modadd.sv
// Adds two values in 0..M-1 and folds the result back into range.
// A single subtraction is tried; anything still out of range becomes zero.
module dds_modadd #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] m_i,
  output logic [W-1:0] y_o
);
  logic [W:0] sum;
  logic [W:0] red;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    red = (sum >= {1'b0, m_i}) ? (sum - {1'b0, m_i}) : sum;
    if (m_i == '0) begin
      y_o = '0;
    end else if (red >= {1'b0, m_i}) begin
      y_o = '0;
    end else begin
      y_o = red[W-1:0];
    end
  end
endmodule

// File: rtl/dds_phase_norm.sv
// Scales a phase in 0..M-1 to an AW-bit address: floor(phase * 2^AW / M).
// Restoring long division, one quotient bit per unrolled stage.
module dds_phase_norm #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 8
) (
  input  logic [W-1:0]  phase_i,
  input  logic [W-1:0]  m_i,
  output logic [AW-1:0] addr_o
);
  logic [W-1:0]  rem [AW];
  logic [AW-1:0] quo;

  assign rem[0] = phase_i;

  for (genvar i = 0; i < AW; i++) begin : g_stage
    logic [W:0] dbl;
    assign dbl = {rem[i], 1'b0};
    assign quo[AW-1-i] = (dbl >= {1'b0, m_i});
    if (i < AW - 1) begin : g_next
      logic [W-1:0] diff;
      assign diff = dbl[W-1:0] - m_i;
      assign rem[i+1] = quo[AW-1-i] ? diff : dbl[W-1:0];
    end
  end

  assign addr_o = (m_i == '0) ? '0 : quo;
endmodule

// File: rtl/dds_sine_shape.sv
// Piecewise-parabolic sine: each half-wave is x*(Q-x), scaled to the
// magnitude range, mirrored around mid-scale for the second half.
module dds_sine_shape
  import dds_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0]     addr_i,
  output logic [SAMP_W-1:0] samp_o
);
  localparam int unsigned QW   = AW - 1;
  localparam int unsigned PW   = 2 * QW + 1;
  localparam int          SH   = 2 * int'(AW) - int'(SAMP_W) - 3;
  localparam logic [PW-1:0] MAXMAG = PW'((1 << (SAMP_W - 1)) - 1);

  logic [QW-1:0]     x;
  logic [QW:0]       cx;
  logic [PW-1:0]     prod;
  logic [PW-1:0]     scaled;
  logic [SAMP_W-2:0] mag;

  assign x    = addr_i[QW-1:0];
  assign cx   = {1'b1, {QW{1'b0}}} - {1'b0, x};
  assign prod = PW'(x) * PW'(cx);

  if (SH >= 0) begin : g_rsh
    assign scaled = prod >> SH;
  end else begin : g_lsh
    assign scaled = prod << (-SH);
  end

  assign mag    = (scaled > MAXMAG) ? MAXMAG[SAMP_W-2:0] : scaled[SAMP_W-2:0];
  assign samp_o = addr_i[AW-1] ? {1'b0, ~mag} : {1'b1, mag};
endmodule

// File: rtl/dds_modm_core.sv
// Modulo-M phase accumulator with post-accumulator phase offset.
module dds_modm_core
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ACC_W-1:0]  step_i,
  input  logic [ACC_W-1:0]  modulus_i,
  input  logic [ACC_W-1:0]  offset_i,
  output logic [SAMP_W-1:0] sample_o
);
  // captured configuration
  logic [ACC_W-1:0]  step_q;
  logic [ACC_W-1:0]  mod_q;
  logic [ACC_W-1:0]  off_q;
  // datapath state
  logic [ACC_W-1:0]  acc_q;
  logic [ADDR_W-1:0] addr_q;
  // combinational results
  logic [ACC_W-1:0]  acc_nxt;
  logic [ACC_W-1:0]  phase_w;
  logic [ADDR_W-1:0] addr_nxt;
  logic [SAMP_W-1:0] samp_nxt;

  dds_modadd #(.W(ACC_W)) u_acc_add (
    .a_i (acc_q),
    .b_i (step_q),
    .m_i (mod_q),
    .y_o (acc_nxt)
  );

  dds_modadd #(.W(ACC_W)) u_off_add (
    .a_i (acc_q),
    .b_i (off_q),
    .m_i (mod_q),
    .y_o (phase_w)
  );

  dds_phase_norm #(.W(ACC_W), .AW(ADDR_W)) u_norm (
    .phase_i (phase_w),
    .m_i     (mod_q),
    .addr_o  (addr_nxt)
  );

  dds_sine_shape #(.AW(ADDR_W)) u_shape (
    .addr_i (addr_q),
    .samp_o (samp_nxt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      step_q   <= '0;
      mod_q    <= '0;
      off_q    <= '0;
      acc_q    <= '0;
      addr_q   <= '0;
      sample_o <= SAMP_MID;
    end else begin
      step_q   <= step_i;
      mod_q    <= modulus_i;
      off_q    <= offset_i;
      acc_q    <= acc_nxt;
      addr_q   <= addr_nxt;
      sample_o <= samp_nxt;
    end
  end
endmodule

// File: rtl/dds_modm_chk.sv
module dds_modm_chk
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ACC_W-1:0]  mod_q,
  input logic [ACC_W-1:0]  acc_q,
  input logic [ACC_W-1:0]  phase,
  input logic [ADDR_W-1:0] addr_q,
  input logic [SAMP_W-1:0] sample_o
);
  // R2/R3: accumulator never leaves 0..M-1 of the modulus it was built with
  a_r2_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mod_q) != '0) |-> (acc_q < $past(mod_q)));

  // R4: zero modulus parks accumulator and address
  a_r4_zero_mod_parks: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mod_q) == '0) |-> (acc_q == '0 && addr_q == '0));

  // R6: folded phase stays inside the modulus range
  a_r6_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    (mod_q != '0) |-> (phase < mod_q));

  // R8: upper half of the address range yields the lower half of codes
  a_r8_half_polarity: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sample_o[SAMP_W-1] == !$past(addr_q[ADDR_W-1])));
endmodule

bind dds_modm_core dds_modm_chk #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk_i),
  .rst      (rst_i),
  .mod_q    (mod_q),
  .acc_q    (acc_q),
  .phase    (phase_w),
  .addr_q   (addr_q),
  .sample_o (sample_o)
);

// File: tb/test_dds_modm_core.sv
module test_dds_modm_core;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W  = 16;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic [15:0] stp;
    logic [15:0] modv;
    logic [15:0] offs;
    logic [15:0] len;
  } vec_t;

  // step, modulus, offset, cycles
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'd1,     16'd256,   16'd0,     16'd300},  // R10 R2 power-of-two ring
    '{16'd3,     16'd100,   16'd0,     16'd120},  // R2 non-power-of-two modulus
    '{16'd7,     16'd1000,  16'd500,   16'd150},  // R6 half-cycle offset
    '{16'd99,    16'd100,   16'd99,    16'd60},   // R2 step = M-1
    '{16'd5,     16'd0,     16'd3,     16'd20},   // R4 zero modulus
    '{16'd300,   16'd200,   16'd0,     16'd30},   // R3 step above modulus
    '{16'd10,    16'd1000,  16'd0,     16'd60},   // R2 lead-in
    '{16'd10,    16'd50,    16'd0,     16'd30},   // R3 modulus lowered
    '{16'd0,     16'd777,   16'd123,   16'd20},   // R2 zero step holds
    '{16'd65534, 16'd65535, 16'd65534, 16'd40}    // R2 R6 width overflow
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [ACC_W-1:0]  step_i, modulus_i, offset_i;
  logic [7:0]        sample_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dds_modm_core #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) i_dds_modm_core (
    .clk_i     (clk),
    .rst_i     (rst),
    .step_i    (step_i),
    .modulus_i (modulus_i),
    .offset_i  (offset_i),
    .sample_o  (sample_o)
  );

  // ---- reference model built from the requirements ----
  function automatic int unsigned mwrap(int unsigned a, int unsigned b, int unsigned m);
    int unsigned s;
    if (m == 0) return 0;
    s = a + b;
    if (s >= m) s = s - m;
    if (s >= m) s = 0;
    return s;
  endfunction

  function automatic int unsigned mnorm(int unsigned p, int unsigned m);
    if (m == 0) return 0;
    return int'((longint'(p) * 256) / longint'(m));
  endfunction

  function automatic int unsigned msine(int unsigned a);
    int unsigned x, g;
    x = a % 128;
    g = (x * (128 - x)) >> 5;
    if (g > 127) g = 127;
    return (a >= 128) ? (127 - g) : (128 + g);
  endfunction

  int unsigned m_step, m_mod, m_off, m_acc, m_addr, m_samp;

  always @(posedge clk) begin
    if (rst) begin
      m_step <= 0; m_mod <= 0; m_off <= 0;
      m_acc  <= 0; m_addr <= 0; m_samp <= 128;
    end else begin
      m_step <= step_i;
      m_mod  <= modulus_i;
      m_off  <= offset_i;
      m_acc  <= mwrap(m_acc, m_step, m_mod);
      m_addr <= mnorm(mwrap(m_acc, m_off, m_mod), m_mod);
      m_samp <= msine(m_addr);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int s, input int m, input int o);
    step_i    = ACC_W'(s);
    modulus_i = ACC_W'(m);
    offset_i  = ACC_W'(o);
  endtask

  task automatic settle_and_check(input string tag, input int exp);
    repeat (3) @(negedge clk);
    check(tag, sample_o, exp);
  endtask

  initial begin
    rst = 1'b1;
    set_cfg(0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 reset held", sample_o, 128);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", sample_o, 128);

    // vector table walked against the model
    for (int v = 0; v < NV; v++) begin
      set_cfg(VECS[v].stp, VECS[v].modv, VECS[v].offs);
      for (int c = 0; c < int'(VECS[v].len); c++) begin
        @(negedge clk);
        check("R2 R3 R4 R6 R7 R8 R10 model", sample_o, m_samp);
      end
    end

    // mid-run reset
    set_cfg(5, 100, 0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", sample_o, 128);

    // latency of an offset step: R5 R9
    rst = 1'b0;
    set_cfg(0, 256, 0);
    @(negedge clk);
    check("R5 idle", sample_o, 128);
    offset_i = 16'd64;
    @(negedge clk);
    check("R9 edge1", sample_o, 128);
    @(negedge clk);
    check("R9 edge2", sample_o, 128);
    @(negedge clk);
    check("R5 R9 edge3 peak", sample_o, 255);

    // shaper landmarks: R8
    offset_i = 16'd192; settle_and_check("R8 trough", 0);
    offset_i = 16'd128; settle_and_check("R8 falling zero", 127);
    offset_i = 16'd0;   settle_and_check("R8 rising zero", 128);

    // address scaling with non-power-of-two modulus: R7
    set_cfg(0, 1000, 250); settle_and_check("R7 quarter of 1000", 255);
    set_cfg(0, 1000, 999); settle_and_check("R7 top of range", 124);

    // offset folding: R6 and the R3 rule on the phase sum
    set_cfg(0, 100, 150); settle_and_check("R6 fold once", 127);
    set_cfg(0, 100, 250); settle_and_check("R6 R3 fold to zero", 128);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule